// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Initialization Scheduler

This block decides when an asynchronous, multiplexed-address DRAM must be refreshed, and it sequences the start-up work the memory needs before it may carry normal traffic. It runs from the system clock, whose frequency is a parameter. Every delay is derived from that frequency, rounded down to whole cycles. The block does not drive the memory strobes. It raises a refresh request toward the memory controller, which arbitrates the request against normal accesses and answers with a one-cycle acknowledge once it has run the refresh.

After reset, the scheduler first stays silent for the power-up settling time. It then asks for a burst of back-to-back initialization refreshes. When the last of these is acknowledged, it raises a ready flag. From then on it issues one refresh request per refresh slot. The slot length is the refresh period divided by the number of rows, so that every row is refreshed once per period.

Each request carries a style bit:
- **Counter-based refresh.** The DRAM takes the row from its own internal counter. The controller supplies no address and must keep the write strobe high while the row strobe falls. A low write strobe at that point would put the part into a test mode.
- **Row-only refresh.** The controller drives the row address that the scheduler supplies and keeps the column strobe high. The scheduler keeps this row address in its own counter.

Slots that pass without an acknowledge are queued up to a limit. A slot that arrives when the queue is already full raises an overflow error flag.

Top module: `dram_refresh_sched`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) clears `ref_req_o`, `ready_o`, `overflow_o` and `ref_row_o`, and restarts the power-up sequence.
- R2: After reset is released, `ref_req_o` stays low for exactly WAIT = floor(CLK_HZ * INIT_WAIT_US / 1e6) clock edges and goes high at edge WAIT.
- R3: During initialization, `ref_req_o` is held high without a gap across INIT_REFRESHES acknowledges. `ready_o` stays low until the last of these acknowledges and rises on it, and `ref_req_o` then drops.
- R4: After `ready_o` rises, a refresh slot falls due every SLOT = floor(CLK_HZ * REF_PERIOD_US / (1e6 * 2^ROW_BITS)) cycles. Slots are counted from the edge that raised `ready_o`, and the timing of acknowledges does not move them.
- R5: Once high, `ready_o` stays high until the next reset.
- R6: `ref_row_mode_o` gives the style of the pending request: 1 means row-only refresh using `ref_row_o`, 0 means counter-based refresh, where no address is supplied and the write strobe is held high at the row strobe's fall. The bit is taken from `row_mode_i` while no request is up, and again on each acknowledge. It is stable while a request is waiting.
- R7: `ref_req_o` stays high until it is acknowledged. An acknowledge (`ref_ack_i` high at an edge) given while `ref_req_o` is low has no effect.
- R8: `ref_row_o` increments by one on each acknowledged row-only refresh, including those during initialization. It is unchanged by counter-based acknowledges and wraps from 2^ROW_BITS-1 to 0.
- R9: In run mode, up to MAX_BACKLOG due but unacknowledged slots are held. `ref_req_o` stays high until that many acknowledges have been received.
- R10: A slot that falls due when MAX_BACKLOG slots are already held, with no acknowledge in that cycle, sets `overflow_o`. The flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| row_mode_i | input | 1 | Refresh style to use: 1 row-only, 0 counter-based |
| ref_ack_i | input | 1 | One-cycle acknowledge from the controller that a refresh was run |
| ref_req_o | output | 1 | Refresh request, held until acknowledged |
| ref_row_mode_o | output | 1 | Style of the request in flight |
| ref_row_o | output | ROW_BITS | Row address for row-only refresh |
| ready_o | output | 1 | Initialization finished; normal access allowed |
| overflow_o | output | 1 | Sticky flag: refresh backlog exceeded |

## Verification
The request timing is tried with acknowledges given promptly, given late, withheld across many slots, and given while no request is up. This separates a slot timer that runs freely from one that restarts on each acknowledge. It also shows whether queued slots are all served, and whether stray acknowledges leak into the state. The style input is switched while a request waits and between requests, and both styles are acknowledged. This shows that the style bit is held while a request waits and that only row-only refreshes advance the row counter. Row-only refreshes continue until the counter wraps. The power-up wait and the initialization burst are checked at the exact edges where the request and the ready flag must change.

// File: rtl/dram_refresh_pkg.sv
`timescale 1ns/1ps
package dram_refresh_pkg;

  typedef enum logic [1:0] {
    PH_WAIT = 2'd0,
    PH_INIT = 2'd1,
    PH_RUN  = 2'd2
  } phase_t;

  // Whole cycles for num/den, never below one.
  function automatic int cycles_of(input longint num, input longint den);
    longint q;
    q = num / den;
    if (q < 1) q = 1;
    return int'(q);
  endfunction

endpackage

// File: rtl/refresh_tick_timer.sv
`timescale 1ns/1ps
module refresh_tick_timer #(
  parameter int LIMIT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick_o
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = en && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (en) begin
      cnt_q <= tick_o ? '0 : cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/refresh_backlog.sv
`timescale 1ns/1ps
module refresh_backlog #(
  parameter int DEPTH = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic take_i,
  output logic due_next_o,
  output logic overflow_o
);
  localparam int BW = $clog2(DEPTH + 1);
  localparam logic [BW-1:0] FULL = BW'(DEPTH);

  logic [BW-1:0] lvl_q, lvl_d;
  logic          ovf_q, ovf_d;

  always_comb begin
    lvl_d = lvl_q;
    ovf_d = ovf_q;
    if (tick_i && !take_i) begin
      if (lvl_q == FULL) ovf_d = 1'b1;
      else               lvl_d = lvl_q + BW'(1);
    end else if (!tick_i && take_i && (lvl_q != '0)) begin
      lvl_d = lvl_q - BW'(1);
    end
  end

  assign due_next_o = (lvl_d != '0);
  assign overflow_o = ovf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      lvl_q <= lvl_d;
      ovf_q <= ovf_d;
    end
  end
endmodule

// File: rtl/refresh_row_counter.sv
`timescale 1ns/1ps
module refresh_row_counter #(
  parameter int BITS = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step_i,
  output logic [BITS-1:0] row_o
);
  always_ff @(posedge clk) begin
    if (rst)         row_o <= '0;
    else if (step_i) row_o <= row_o + BITS'(1);
  end
endmodule

// File: rtl/dram_refresh_sched.sv
`timescale 1ns/1ps
module dram_refresh_sched
  import dram_refresh_pkg::*;
#(
  parameter int CLK_HZ         = 50_000_000,
  parameter int REF_PERIOD_US  = 64_000,
  parameter int ROW_BITS       = 12,
  parameter int INIT_WAIT_US   = 200,
  parameter int INIT_REFRESHES = 8,
  parameter int MAX_BACKLOG    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                row_mode_i,
  input  logic                ref_ack_i,
  output logic                ref_req_o,
  output logic                ref_row_mode_o,
  output logic [ROW_BITS-1:0] ref_row_o,
  output logic                ready_o,
  output logic                overflow_o
);
  localparam int WAIT_CYC = cycles_of(longint'(CLK_HZ) * longint'(INIT_WAIT_US),
                                      longint'(1_000_000));
  localparam int SLOT_CYC = cycles_of(longint'(CLK_HZ) * longint'(REF_PERIOD_US),
                                      longint'(1_000_000) << ROW_BITS);
  localparam int ICW = (INIT_REFRESHES > 1) ? $clog2(INIT_REFRESHES) : 1;
  localparam logic [ICW-1:0] INIT_LAST = ICW'(INIT_REFRESHES - 1);

  phase_t         phase_q;
  logic           req_q, ready_q, kind_q;
  logic [ICW-1:0] init_cnt_q;
  logic           take, run_take, wait_tick, slot_tick, due_next;

  assign take     = ref_ack_i && req_q;
  assign run_take = take && (phase_q == PH_RUN);

  refresh_tick_timer #(.LIMIT(WAIT_CYC)) u_wait (
    .clk(clk), .rst(rst), .en(phase_q == PH_WAIT), .tick_o(wait_tick)
  );

  refresh_tick_timer #(.LIMIT(SLOT_CYC)) u_slot (
    .clk(clk), .rst(rst), .en(phase_q == PH_RUN), .tick_o(slot_tick)
  );

  refresh_backlog #(.DEPTH(MAX_BACKLOG)) u_backlog (
    .clk(clk), .rst(rst), .tick_i(slot_tick), .take_i(run_take),
    .due_next_o(due_next), .overflow_o(overflow_o)
  );

  refresh_row_counter #(.BITS(ROW_BITS)) u_row (
    .clk(clk), .rst(rst), .step_i(take && kind_q), .row_o(ref_row_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_WAIT;
      req_q      <= 1'b0;
      ready_q    <= 1'b0;
      kind_q     <= 1'b0;
      init_cnt_q <= '0;
    end else begin
      if (!req_q || take) kind_q <= row_mode_i;
      unique case (phase_q)
        PH_WAIT: begin
          if (wait_tick) begin
            phase_q <= PH_INIT;
            req_q   <= 1'b1;
          end
        end
        PH_INIT: begin
          if (take) begin
            if (init_cnt_q == INIT_LAST) begin
              phase_q <= PH_RUN;
              req_q   <= 1'b0;
              ready_q <= 1'b1;
            end else begin
              init_cnt_q <= init_cnt_q + ICW'(1);
            end
          end
        end
        PH_RUN:  req_q <= due_next;
        default: phase_q <= PH_WAIT;
      endcase
    end
  end

  assign ref_req_o      = req_q;
  assign ready_o        = ready_q;
  assign ref_row_mode_o = kind_q;
endmodule

// File: rtl/dram_refresh_sched_chk.sv
`timescale 1ns/1ps
module dram_refresh_sched_chk
  import dram_refresh_pkg::*;
#(
  parameter int CLK_HZ         = 50_000_000,
  parameter int REF_PERIOD_US  = 64_000,
  parameter int ROW_BITS       = 12,
  parameter int INIT_WAIT_US   = 200,
  parameter int INIT_REFRESHES = 8,
  parameter int MAX_BACKLOG    = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                ref_ack_i,
  input logic                ref_req_o,
  input logic                ref_row_mode_o,
  input logic [ROW_BITS-1:0] ref_row_o,
  input logic                ready_o,
  input logic                overflow_o
);
  localparam int WAIT_CYC = cycles_of(longint'(CLK_HZ) * longint'(INIT_WAIT_US),
                                      longint'(1_000_000));

  int unsigned since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= 0;
    else if (since_rst < WAIT_CYC) since_rst <= since_rst + 1;
  end

  // R2
  p_quiet_wait_r2: assert property (@(posedge clk) disable iff (rst)
    ref_req_o |-> (since_rst >= WAIT_CYC));

  // R5
  p_ready_holds_r5: assert property (@(posedge clk) disable iff (rst)
    ready_o |=> ready_o);

  // R6 and R7
  p_hold_request_r7: assert property (@(posedge clk) disable iff (rst)
    (ref_req_o && !ref_ack_i) |=> (ref_req_o && $stable(ref_row_mode_o)));

  // R8
  p_row_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !(ref_ack_i && ref_req_o && ref_row_mode_o) |=> $stable(ref_row_o));

  p_row_step_r8: assert property (@(posedge clk) disable iff (rst)
    (ref_ack_i && ref_req_o && ref_row_mode_o) |=>
      (ref_row_o == ROW_BITS'($past(ref_row_o) + 1'b1)));

  // R10
  p_overflow_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    overflow_o |=> overflow_o);
endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(
  .CLK_HZ(CLK_HZ), .REF_PERIOD_US(REF_PERIOD_US), .ROW_BITS(ROW_BITS),
  .INIT_WAIT_US(INIT_WAIT_US), .INIT_REFRESHES(INIT_REFRESHES),
  .MAX_BACKLOG(MAX_BACKLOG)
) u_chk (
  .clk(clk), .rst(rst), .ref_ack_i(ref_ack_i), .ref_req_o(ref_req_o),
  .ref_row_mode_o(ref_row_mode_o), .ref_row_o(ref_row_o),
  .ready_o(ready_o), .overflow_o(overflow_o)
);

// File: tb/tb_dram_refresh_sched.sv
`timescale 1ns/1ps
module tb_dram_refresh_sched;
  localparam int P_CLK   = 50_000_000;
  localparam int P_PER   = 160;
  localparam int P_ROWB  = 4;
  localparam int P_WUS   = 20;
  localparam int P_INIT  = 8;
  localparam int P_BACK  = 8;
  localparam int W_CYC   = (P_CLK / 1_000_000) * P_WUS;
  localparam int S_CYC   = ((P_CLK / 1_000_000) * P_PER) / (1 << P_ROWB);
  localparam int ROWS    = 1 << P_ROWB;

  logic clk = 1'b0, rst = 1'b1, row_mode = 1'b0, ack = 1'b0;
  logic req, kind, ready, ovf;
  logic [P_ROWB-1:0] row;

  int checks = 0, errors = 0, edge_n = 0, run_base = 0;
  bit done = 1'b0;

  dram_refresh_sched #(
    .CLK_HZ(P_CLK), .REF_PERIOD_US(P_PER), .ROW_BITS(P_ROWB),
    .INIT_WAIT_US(P_WUS), .INIT_REFRESHES(P_INIT), .MAX_BACKLOG(P_BACK)
  ) dut (
    .clk(clk), .rst(rst), .row_mode_i(row_mode), .ref_ack_i(ack),
    .ref_req_o(req), .ref_row_mode_o(kind), .ref_row_o(row),
    .ready_o(ready), .overflow_o(ovf)
  );

  always #10 clk = ~clk;

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      edge_n++;
      @(negedge clk);
    end
  endtask

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic ack_once();
    ack = 1'b1;
    step(1);
    ack = 1'b0;
  endtask

  task automatic wait_tick();
    step(S_CYC - ((edge_n - run_base) % S_CYC));
  endtask

  task automatic t_reset();
    step(3);
    check("R1", "req in reset", req, 0);
    check("R1", "ready in reset", ready, 0);
    check("R1", "overflow in reset", ovf, 0);
    check("R1", "row in reset", row, 0);
    rst = 1'b0;
    edge_n = 0;
  endtask

  task automatic t_init_wait();
    row_mode = 1'b1;
    step(W_CYC - 1);
    check("R2", "req one edge before wait ends", req, 0);
    step(1);
    check("R2", "req when wait ends", req, 1);
    check("R3", "ready before init burst", ready, 0);
    check("R6", "style of init request", kind, 1);
  endtask

  task automatic t_init_burst();
    for (int i = 0; i < P_INIT; i++) begin
      ack_once();
      if (i < P_INIT - 1) begin
        check("R3", "req held during burst", req, 1);
        check("R3", "ready during burst", ready, 0);
      end
    end
    run_base = edge_n;
    check("R3", "ready after last init ack", ready, 1);
    check("R3", "req after last init ack", req, 0);
    check("R8", "row after init row-only refreshes", row, P_INIT % ROWS);
  endtask

  task automatic t_interval();
    step(S_CYC - 1);
    check("R4", "req one edge before first slot", req, 0);
    step(1);
    check("R4", "req at first slot", req, 1);
    row_mode = 1'b0;
    step(2);
    check("R7", "req held without ack", req, 1);
    check("R6", "style held while waiting", kind, 1);
    ack_once();
    check("R8", "row after row-only ack", row, (P_INIT + 1) % ROWS);
    check("R7", "req after ack", req, 0);
    step(1);
    check("R6", "style follows input when idle", kind, 0);
    wait_tick();
    check("R4", "req at second slot despite late ack", req, 1);
    check("R6", "counter-based style", kind, 0);
    ack_once();
    check("R8", "row unchanged by counter-based ack", row, (P_INIT + 1) % ROWS);
    check("R5", "ready stays high", ready, 1);
  endtask

  task automatic t_backlog();
    for (int k = 0; k < P_BACK; k++) begin
      wait_tick();
      check("R9", "req with backlog", req, 1);
      check("R10", "no overflow within limit", ovf, 0);
    end
    wait_tick();
    check("R10", "overflow past limit", ovf, 1);
    for (int k = 0; k < P_BACK; k++) begin
      ack_once();
      check("R9", "req while draining backlog", req, (k < P_BACK - 1) ? 1 : 0);
    end
    check("R10", "overflow sticky", ovf, 1);
    check("R8", "row unchanged by counter-based backlog", row, (P_INIT + 1) % ROWS);
  endtask

  task automatic t_stray_ack();
    row_mode = 1'b1;
    ack_once();
    check("R7", "stray ack leaves row", row, (P_INIT + 1) % ROWS);
    check("R7", "stray ack raises no req", req, 0);
    step(1);
    check("R6", "style follows input when idle", kind, 1);
  endtask

  task automatic t_wrap();
    int exp_row;
    exp_row = (P_INIT + 1) % ROWS;
    while (exp_row != 0) begin
      wait_tick();
      check("R4", "req at slot", req, 1);
      ack_once();
      exp_row = (exp_row + 1) % ROWS;
      check("R8", "row step and wrap", row, exp_row);
    end
  endtask

  task automatic t_rerun_reset();
    rst = 1'b1;
    step(1);
    check("R1", "ready after late reset", ready, 0);
    check("R1", "overflow after late reset", ovf, 0);
    check("R1", "row after late reset", row, 0);
    check("R1", "req after late reset", req, 0);
    rst = 1'b0;
  endtask

  initial begin
    t_reset();
    t_init_wait();
    t_init_burst();
    t_interval();
    t_backlog();
    t_stray_ack();
    t_wrap();
    t_rerun_reset();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200_000 * 20);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R4 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule